// File: doc/BRIEF.md
# Interrupt moderation masking timer

This block decides when a host interrupt line may be raised for transmit-done and receive-done completions. Each completion event sets a pending status bit, which stays set until software clears it with a strobe. A 16-bit down-counter, the masking timer, holds the line low while its count is nonzero. The counter is decremented by a tick enable that a prescaler derives from the transmit clock.

Software picks one of four arming modes and writes it with a strobe. The timer can be left unloaded. It can be loaded once at the write. It can also re-arm itself either when software has drained all pending status or when a new status first appears after an idle spell.

Receive completions can skip the mask. A frame at or below a programmable size threshold can do so, and so can a frame flagged high priority. In either case a bypass flag is latched and stays set until software clears receive-done. Bus decoding and data movement sit outside the block.

Top module: `irq_moderator`

## Requirements
- R1: After reset the line is low, the timer count is zero, no status is pending, the bypass flag is clear and the prescaler counter is zero.
- R2: A transmit-done or receive-done event sets its pending bit. The bit stays set until the matching clear strobe. An event in the same cycle as a clear leaves the bit set. With the timer at zero, any pending bit drives the line high, starting in the cycle after the event edge.
- R3: A mode write strobe carrying a nonzero mode loads the timer with the period input. A write of mode 0 leaves the count as it is. A loaded period of zero causes no masking.
- R4: On each tick the count drops by exactly one. It holds at zero and never wraps. While the count is nonzero the line stays low unless the bypass flag is set.
- R5: The prescaler counter counts clock cycles from zero. When it reaches the limit minus one it produces a one-cycle tick and returns to zero. The limit is 2 when the scale input is 0 and 20 when it is 1. A counter already at or above a newly selected limit minus one ticks at once.
- R6: In mode 2, the full period is reloaded on the edge where clear strobes take the pending status from some set to none set.
- R7: In mode 3, the full period is reloaded on the edge where a new event takes the pending status from none set to some set. That first status is therefore masked.
- R8: The size select sets the inclusive byte threshold: 0 gives 64, 1 gives 128, 2 gives 256 and 3 gives 512. With small-frame bypass enabled, a receive event whose length is at or below the threshold sets the bypass flag.
- R9: With high-priority bypass enabled, a receive event flagged high priority sets the bypass flag. With both bypass enables off, receive frames are masked like any other completion.
- R10: The bypass flag is cleared only by the receive clear strobe, and a bypass-setting event in the same cycle wins. The line equals pending AND (count is zero OR bypass flag).
- R11: When a load and a tick fall on the same edge, the load wins, so the count equals the period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | transmit clock |
| rst_n | input | 1 | active-low asynchronous reset |
| arm_mode | input | 2 | arming mode (0 off, 1 one-shot, 2 re-arm on drain, 3 re-arm on new status) |
| mode_wr | input | 1 | strobe marking a write of the mode field |
| mask_period | input | PER_W | value loaded into the masking timer |
| tick_x10 | input | 1 | prescale select: 0 divides by 2, 1 divides by 20 |
| small_sel | input | 2 | small-frame size threshold code |
| small_byp_en | input | 1 | enables bypass for small receive frames |
| hipri_byp_en | input | 1 | enables bypass for high-priority receive frames |
| tx_done_evt | input | 1 | transmit completion event |
| rx_done_evt | input | 1 | receive completion event |
| rx_len | input | LEN_W | byte length of the completed receive frame |
| rx_hipri | input | 1 | completed receive frame is high priority |
| tx_clr | input | 1 | software clear of transmit-done |
| rx_clr | input | 1 | software clear of receive-done |
| irq_out | output | 1 | host interrupt line |

## Verification
Every state element updates on one clock edge, and the line is a combinational function of those registers. An event, clear, mode write or tick therefore shows on the line in the cycle right after the edge that sampled it. The timer state lasts about period times divisor cycles. The bench drives inputs on the falling edge and advances a reference model by one edge. After the next rising edge it compares the line at the following falling edge, so every expected value lines up exactly with the register stage that produces it.

// File: rtl/irq_moderator.sv
module irq_moderator #(
  parameter int PER_W    = 16,
  parameter int LEN_W    = 16,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       arm_mode,
  input  logic             mode_wr,
  input  logic [PER_W-1:0] mask_period,
  input  logic             tick_x10,
  input  logic [1:0]       small_sel,
  input  logic             small_byp_en,
  input  logic             hipri_byp_en,
  input  logic             tx_done_evt,
  input  logic             rx_done_evt,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_hipri,
  input  logic             tx_clr,
  input  logic             rx_clr,
  output logic             irq_out
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
  localparam logic [LEN_W-1:0] THR_BASE = LEN_W'(64);

  logic [PW-1:0]    pre_q;
  logic [PER_W-1:0] cnt_q;
  logic             tx_q, rx_q, byp_q;

  wire [PW-1:0] lim  = tick_x10 ? LIM_SLOW : LIM_FAST;
  wire          tick = (pre_q >= lim);

  wire tx_n   = tx_done_evt | (tx_q & ~tx_clr);
  wire rx_n   = rx_done_evt | (rx_q & ~rx_clr);
  wire pend_q = tx_q | rx_q;
  wire pend_n = tx_n | rx_n;

  wire [LEN_W-1:0] thr = THR_BASE << small_sel;
  wire byp_hit = rx_done_evt & ((small_byp_en & (rx_len <= thr)) |
                                (hipri_byp_en & rx_hipri));

  wire load = (mode_wr & (arm_mode != 2'b00))
            | ((arm_mode == 2'b10) & pend_q & ~pend_n)
            | ((arm_mode == 2'b11) & ~pend_q & pend_n);

  wire masking = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= mask_period;
    else if (tick & masking) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      byp_q <= byp_hit | (byp_q & ~rx_clr);
    end
  end

  assign irq_out = pend_q & (~masking | byp_q);
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       arm_mode,
  input logic             mode_wr,
  input logic [PER_W-1:0] mask_period,
  input logic             rx_clr,
  input logic             rx_done_evt,
  input logic [PER_W-1:0] cnt,
  input logic             tick,
  input logic             byp,
  input logic             pend,
  input logic             irq,
  input logic             load
);
  assert_idle_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && pend) |-> irq);

  assert_mask_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !byp) |-> !irq);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !load) |=> cnt == $past(cnt) - 1'b1);

  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> cnt == '0);

  assert_write_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && arm_mode != 2'b00) |=> cnt == $past(mask_period));

  assert_tick_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_byp_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr && !rx_done_evt) |=> !byp);
endmodule

bind irq_moderator irq_moderator_chk #(.PER_W(PER_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .arm_mode(arm_mode), .mode_wr(mode_wr),
  .mask_period(mask_period), .rx_clr(rx_clr), .rx_done_evt(rx_done_evt),
  .cnt(cnt_q), .tick(tick), .byp(byp_q), .pend(pend_q), .irq(irq_out),
  .load(load)
);

// File: tb/irq_moderator_test.sv
module irq_moderator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  arm_mode = 2'b00;
  logic        mode_wr = 1'b0;
  logic [15:0] mask_period = '0;
  logic        tick_x10 = 1'b0;
  logic [1:0]  small_sel = 2'b00;
  logic        small_byp_en = 1'b0;
  logic        hipri_byp_en = 1'b0;
  logic        tx_done_evt = 1'b0;
  logic        rx_done_evt = 1'b0;
  logic [15:0] rx_len = '0;
  logic        rx_hipri = 1'b0;
  logic        tx_clr = 1'b0;
  logic        rx_clr = 1'b0;
  logic        irq_out;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_pre, m_cnt;
  bit m_tx, m_rx, m_byp;

  always #5 clk = ~clk;

  irq_moderator uut (
    .clk(clk), .rst_n(rst_n), .arm_mode(arm_mode), .mode_wr(mode_wr),
    .mask_period(mask_period), .tick_x10(tick_x10), .small_sel(small_sel),
    .small_byp_en(small_byp_en), .hipri_byp_en(hipri_byp_en),
    .tx_done_evt(tx_done_evt), .rx_done_evt(rx_done_evt), .rx_len(rx_len),
    .rx_hipri(rx_hipri), .tx_clr(tx_clr), .rx_clr(rx_clr), .irq_out(irq_out)
  );

  function automatic int thr_of(input logic [1:0] s);
    case (s)
      2'd0: return 64;
      2'd1: return 128;
      2'd2: return 256;
      default: return 512;
    endcase
  endfunction

  function automatic bit exp_irq();
    return (m_tx || m_rx) && (m_cnt == 0 || m_byp);
  endfunction

  task automatic model_step();
    int lim;
    bit tk, txn, rxn, pq, pn, hit, ld;
    lim = tick_x10 ? 19 : 1;
    tk  = (m_pre >= lim);
    txn = tx_done_evt || (m_tx && !tx_clr);
    rxn = rx_done_evt || (m_rx && !rx_clr);
    pq  = m_tx || m_rx;
    pn  = txn || rxn;
    hit = rx_done_evt && ((small_byp_en && int'(rx_len) <= thr_of(small_sel)) ||
                          (hipri_byp_en && rx_hipri));
    ld  = (mode_wr && arm_mode != 2'b00) || (arm_mode == 2'b10 && pq && !pn) ||
          (arm_mode == 2'b11 && !pq && pn);
    if (ld) m_cnt = int'(mask_period);
    else if (tk && m_cnt > 0) m_cnt = m_cnt - 1;
    m_pre = tk ? 0 : m_pre + 1;
    m_tx  = txn;
    m_rx  = rxn;
    m_byp = hit || (m_byp && !rx_clr);
  endtask

  task automatic check_line(input bit expv);
    compared++;
    if (irq_out !== expv) begin
      mismatched++;
      $display("FAIL %s at %0t: irq_out=%0b expected %0b", cur_req, $time, irq_out, expv);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      check_line(exp_irq());
      mode_wr = 0; tx_done_evt = 0; rx_done_evt = 0; tx_clr = 0; rx_clr = 0;
    end
  endtask

  task automatic set_mode(input logic [1:0] md, input int per);
    arm_mode = md; mask_period = 16'(per); mode_wr = 1;
    cyc(1);
  endtask

  task automatic clear_all();
    tx_clr = 1; rx_clr = 1;
    cyc(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check_line(1'b0);
    rst_n = 1;
    m_pre = 0; m_cnt = 0; m_tx = 0; m_rx = 0; m_byp = 0;
    cyc(3);

    // R2 status set, hold, clear, event beats clear
    cur_req = "R2";
    tx_done_evt = 1; cyc(1);
    cyc(4);
    tx_clr = 1; cyc(1);
    rx_done_evt = 1; rx_clr = 1; cyc(2);
    rx_clr = 1; cyc(2);

    // R3 one-shot load, zero period, mode 0 write keeps count
    cur_req = "R3";
    set_mode(2'b01, 5);
    tx_done_evt = 1; cyc(14);
    clear_all();
    set_mode(2'b01, 0);
    tx_done_evt = 1; cyc(3);
    clear_all();
    set_mode(2'b01, 6);
    set_mode(2'b00, 0);
    tx_done_evt = 1; cyc(14);
    clear_all();

    // R4 count down and hold at zero
    cur_req = "R4";
    rx_done_evt = 1;
    set_mode(2'b01, 3);
    cyc(10);
    clear_all();

    // R5 divide by 20, switch back
    cur_req = "R5";
    tick_x10 = 1;
    set_mode(2'b01, 2);
    tx_done_evt = 1; cyc(45);
    clear_all();
    cyc(7);
    tick_x10 = 0; cyc(4);

    // R6 re-arm on drain
    cur_req = "R6";
    set_mode(2'b10, 4);
    cyc(9);
    tx_done_evt = 1; cyc(2);
    clear_all();
    tx_done_evt = 1; cyc(12);
    rx_done_evt = 1; cyc(1);
    tx_clr = 1; cyc(2);
    rx_clr = 1; cyc(1);
    rx_done_evt = 1; cyc(10);
    clear_all();

    // R7 re-arm on new status
    cur_req = "R7";
    set_mode(2'b11, 4);
    cyc(10);
    rx_done_evt = 1; cyc(12);
    tx_done_evt = 1; cyc(2);
    clear_all();
    tx_done_evt = 1; cyc(10);
    clear_all();

    // R8 size thresholds at and just above the limit while masked
    cur_req = "R8";
    small_byp_en = 1;
    for (int s = 0; s < 4; s++) begin
      small_sel = 2'(s);
      set_mode(2'b01, 30);
      rx_done_evt = 1; rx_len = 16'(thr_of(2'(s)) + 1); cyc(2);
      rx_clr = 1; cyc(1);
      rx_done_evt = 1; rx_len = 16'(thr_of(2'(s))); cyc(2);
      rx_clr = 1; cyc(1);
    end
    small_byp_en = 0;
    set_mode(2'b01, 30);
    rx_done_evt = 1; rx_len = 16'd10; cyc(2);
    rx_clr = 1; cyc(1);

    // R9 high priority bypass
    cur_req = "R9";
    rx_done_evt = 1; rx_hipri = 1; rx_len = 16'd1500; cyc(1);
    rx_hipri = 0; cyc(1);
    rx_clr = 1; cyc(1);
    hipri_byp_en = 1;
    rx_done_evt = 1; rx_hipri = 1; cyc(1);
    rx_hipri = 0; cyc(2);

    // R10 bypass latch clear rules
    cur_req = "R10";
    tx_done_evt = 1; cyc(2);
    tx_clr = 1; cyc(2);
    rx_clr = 1; rx_done_evt = 1; rx_hipri = 1; cyc(1);
    rx_hipri = 0; cyc(1);
    rx_clr = 1; cyc(1);
    tx_done_evt = 1; cyc(3);
    clear_all();
    hipri_byp_en = 0;
    cyc(70);

    // R11 repeated writes across tick edges keep the count loaded
    cur_req = "R11";
    tx_done_evt = 1; cyc(1);
    for (int k = 0; k < 6; k++) set_mode(2'b01, 2);
    cyc(6);
    clear_all();

    // constrained random mix
    cur_req = "R11 random";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        arm_mode = 2'($urandom_range(0, 3));
        mask_period = 16'($urandom_range(0, 12));
        mode_wr = 1;
      end
      if ($urandom_range(0, 299) == 0) tick_x10 = ~tick_x10;
      if ($urandom_range(0, 99) == 0) small_byp_en = ~small_byp_en;
      if ($urandom_range(0, 99) == 0) hipri_byp_en = ~hipri_byp_en;
      small_sel   = 2'($urandom_range(0, 3));
      rx_len      = 16'($urandom_range(0, 700));
      rx_hipri    = ($urandom_range(0, 3) == 0);
      tx_done_evt = ($urandom_range(0, 9) == 0);
      rx_done_evt = ($urandom_range(0, 9) == 0);
      tx_clr      = ($urandom_range(0, 7) == 0);
      rx_clr      = ($urandom_range(0, 7) == 0);
      cyc(1);
    end
    finish_run();
  end
endmodule